// File: doc/BRIEF.md
# Paged NIC Register Interface

This block is the host-side register file of a small Ethernet controller. A host reaches it over a byte-wide bus with a 4-bit offset. Offset 0 is always the command register. The top two command bits choose a register page. Every other offset is therefore decoded as a 6-bit index made of the page and the offset. As a result, one offset can reach a different register when written than when read, and a different register on each page.

The block holds the following state:
- the receive ring page pointers;
- the 16-bit transmit count, remote start address and remote byte count;
- the receive and data configuration bytes;
- the station address and multicast hash tables;
- the interrupt status and mask registers.

It drives a level interrupt from the masked status. It issues a one-cycle transmit request that carries the transmit page and length. It takes single-cycle event strobes from the receive path and the remote-DMA engine. Reads have no side effects: read data is a combinational function of the bus offset and the registered state.

Top module: `paged_nic_regs`

## Requirements
- R1: After reset the interrupt status reads 0x80 and every other register reads 0x00. `irq` and `tx_go` are low, and `tx_len` is 0.
- R2: Offset 0 reads and writes the command byte on every page. Command bits 7:6 select the page (0, 1 or 2) used to decode offsets 1 to 15. Page 1 offset 0x0A reaches a multicast table byte, not an identity byte.
- R3: Page 0 write offsets: 1 ring first page, 2 ring end page, 3 boundary, 4 transmit page, 5/6 transmit count low/high, 7 status clear, 8/9 remote address low/high, 0x0A/0x0B remote count low/high, 0x0C receive config, 0x0E data config, 0x0F interrupt mask. Page 0 read offsets: 3 boundary, 4 transmit status, 7 status, 8/9 remote address low/high.
- R4: On page 1, offsets 1 to 6 read and write station bytes 0 to 5, offset 7 is the current page, and offsets 8 to 15 are multicast bytes 0 to 7. On page 2, offsets 1 and 2 read back the ring first and end pages.
- R5: Each 16-bit value is written one byte at a time, and writing one byte leaves the other byte unchanged.
- R6: A write to the ring first or end page is ignored when its value exceeds `MEM_END_PAGE` (default 0x80). A write to the boundary or current page is ignored when its value is `MEM_END_PAGE` or more.
- R7: A command write with bit 0 (stop) clear clears status bit 7. A command write with stop set only stores the byte: it starts no transmit, changes no status bit and leaves bit 7 set.
- R8: A command write with stop clear and bit 3 or bit 4 set, while the remote byte count is 0, sets status bit 6 at once.
- R9: A command write with stop clear and bit 2 set does four things on the next clock:
  - it raises `tx_go` for one cycle, with `tx_page` and `tx_len` giving the transmit page and count;
  - it makes the transmit status read 0x01;
  - it sets status bit 1;
  - it leaves command bit 2 reading 0.
- R10: Writing the status register clears every bit 6:0 written as 1, and status bit 7 cannot be cleared this way. An event strobe in the same cycle as a clear of its own bit leaves that bit set.
- R11: `irq` is high exactly when status AND mask has a set bit among bits 6:0. Bit 7 never raises it.
- R12: `rx_ok_evt` sets status bit 0 and `rdma_done_evt` sets status bit 6.
- R13: Page 0 offsets 0x0A and 0x0B read 0x50 and 0x43. Offsets with no readable register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` on the current page |
| irq | output | 1 | Level interrupt |
| rx_ok_evt | input | 1 | Good frame received, sets status bit 0 |
| rdma_done_evt | input | 1 | Remote DMA finished, sets status bit 6 |
| tx_go | output | 1 | One-cycle transmit request |
| tx_page | output | 8 | Transmit start page |
| tx_len | output | 16 | Transmit byte count |
| rx_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |

## Verification
The bench targets the following corner cases:
- **Paging.** A design that ignored the page would read back identity bytes or ring pointers where a table byte belongs.
- **Range guard.** The guard uses an inclusive bound for the ring limits and an exclusive bound for the boundary and current page. An off-by-one there would either lose a legal end page or accept an out-of-range pointer.
- **Status bit 7.** Bit 7 must survive a write-one-to-clear and a stop-set command. It must never drive the interrupt; a wrong design would either lose the reset indication or hold a permanent interrupt.
- **Simultaneous set and clear.** An event strobe and a clear of the same bit in one cycle must leave the bit set.
- **Zero-count remote DMA.** This command must set status bit 6.
- **Transmit.** The transmit command must return the transmit bit to zero.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    // Command byte bit positions (bit 1 start and bit 5 no-DMA are stored only)
    localparam int CMD_STOP   = 0;
    localparam int CMD_XMIT   = 2;
    localparam int CMD_RREAD  = 3;
    localparam int CMD_RWRITE = 4;

    // Interrupt status bit positions
    localparam int ST_RX  = 0;
    localparam int ST_TX  = 1;
    localparam int ST_RDC = 6;
    localparam int ST_RST = 7;

    // Register indices {page, offset}
    localparam logic [5:0] P0_RING_FIRST = 6'h01;
    localparam logic [5:0] P0_RING_END   = 6'h02;
    localparam logic [5:0] P0_BNDRY      = 6'h03;
    localparam logic [5:0] P0_TXPG       = 6'h04;
    localparam logic [5:0] P0_TXCNT_LO   = 6'h05;
    localparam logic [5:0] P0_TXCNT_HI   = 6'h06;
    localparam logic [5:0] P0_STATUS     = 6'h07;
    localparam logic [5:0] P0_RADDR_LO   = 6'h08;
    localparam logic [5:0] P0_RADDR_HI   = 6'h09;
    localparam logic [5:0] P0_RCNT_LO    = 6'h0A;
    localparam logic [5:0] P0_RCNT_HI    = 6'h0B;
    localparam logic [5:0] P0_RXCFG      = 6'h0C;
    localparam logic [5:0] P0_DATACFG    = 6'h0E;
    localparam logic [5:0] P0_MASK       = 6'h0F;
    localparam logic [5:0] P1_STATION    = 6'h11;
    localparam logic [5:0] P1_CURPG      = 6'h17;
    localparam logic [5:0] P1_HASH       = 6'h18;
    localparam logic [5:0] P2_RING_FIRST = 6'h21;
    localparam logic [5:0] P2_RING_END   = 6'h22;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  ring_first;
        logic [7:0]  ring_end;
        logic [7:0]  bndry;
        logic [7:0]  cur_pg;
        logic [7:0]  tx_pg;
        logic [7:0]  tx_stat;
        logic [7:0]  rx_cfg;
        logic [7:0]  data_cfg;
        logic [15:0] tx_cnt;
        logic [15:0] raddr;
        logic [15:0] rcnt;
        logic        tx_go;
    } core_regs_t;

endpackage

// File: rtl/nic_byte_table.sv
module nic_byte_table #(
    parameter int         N    = 6,
    parameter logic [5:0] BASE = 6'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [5:0] idx,
    input  logic [7:0] wdata,
    output logic       hit,
    output logic [7:0] rdata
);
    localparam int LO = int'(BASE);
    localparam int HI = LO + N;

    logic [5:0] rel;
    logic [7:0] ent_q [N];

    assign hit = (int'(idx) >= LO) && (int'(idx) < HI);
    assign rel = idx - BASE;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [7:0] ent_d;
        always_comb begin
            ent_d = ent_q[i];
            if (wr_en && hit && (rel == 6'(i))) ent_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (hit && (rel == 6'(i))) rdata = ent_q[i];
        end
    end
endmodule

// File: rtl/nic_intr_ctrl.sv
module nic_intr_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] set_bits,
    input  logic       w1c_en,
    input  logic [7:0] w1c_bits,
    input  logic       rst_clr,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    output logic [7:0] status_q,
    output logic [7:0] mask_q,
    output logic       irq
);
    import nic_regs_pkg::*;

    localparam logic [7:0] CLR_OK = 8'h7F;

    logic [7:0] status_d, mask_d;

    always_comb begin
        status_d = status_q;
        mask_d   = mask_q;
        if (w1c_en)  status_d = status_d & ~(w1c_bits & CLR_OK);
        if (rst_clr) status_d[ST_RST] = 1'b0;
        status_d = status_d | set_bits;   // a new event outranks a clear
        if (mask_we) mask_d = mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 8'h80;
            mask_q   <= 8'h00;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    assign irq = |(status_q & mask_q & CLR_OK);
endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux #(
    parameter logic [7:0] ID0 = 8'h50,
    parameter logic [7:0] ID1 = 8'h43
) (
    input  logic                      is_cmd,
    input  logic [5:0]                idx,
    input  nic_regs_pkg::core_regs_t  regs,
    input  logic [7:0]                status,
    input  logic                      stn_hit,
    input  logic [7:0]                stn_data,
    input  logic                      hash_hit,
    input  logic [7:0]                hash_data,
    output logic [7:0]                rdata
);
    import nic_regs_pkg::*;

    always_comb begin
        rdata = 8'h00;
        if (is_cmd) begin
            rdata = regs.cmd;
        end else if (stn_hit) begin
            rdata = stn_data;
        end else if (hash_hit) begin
            rdata = hash_data;
        end else begin
            case (idx)
                P0_BNDRY:      rdata = regs.bndry;
                P0_TXPG:       rdata = regs.tx_stat;
                P0_STATUS:     rdata = status;
                P0_RADDR_LO:   rdata = regs.raddr[7:0];
                P0_RADDR_HI:   rdata = regs.raddr[15:8];
                P0_RCNT_LO:    rdata = ID0;
                P0_RCNT_HI:    rdata = ID1;
                P1_CURPG:      rdata = regs.cur_pg;
                P2_RING_FIRST: rdata = regs.ring_first;
                P2_RING_END:   rdata = regs.ring_end;
                default:       rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/paged_nic_regs.sv
module paged_nic_regs #(
    parameter int         MEM_END_PAGE = 8'h80,
    parameter int         STATION_N    = 6,
    parameter int         HASH_N       = 8,
    parameter logic [7:0] ID0          = 8'h50,
    parameter logic [7:0] ID1          = 8'h43
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    input  logic        rx_ok_evt,
    input  logic        rdma_done_evt,
    output logic        tx_go,
    output logic [7:0]  tx_page,
    output logic [15:0] tx_len,
    output logic [7:0]  rx_cfg,
    output logic [7:0]  data_cfg
);
    import nic_regs_pkg::*;

    localparam logic [8:0] END_PG = 9'(MEM_END_PAGE);

    core_regs_t regs_d, regs_q;

    logic [5:0] idx;
    logic       is_cmd;
    logic       tbl_wr;
    logic [8:0] wval;
    logic       lim_ok;   // value may be a ring limit (inclusive bound)
    logic       ptr_ok;   // value may be a ring pointer (exclusive bound)

    logic [7:0] set_bits;
    logic       rst_clr, w1c_en, mask_we;
    logic [7:0] status_q, mask_q;

    logic       stn_hit, hash_hit;
    logic [7:0] stn_data, hash_data;

    assign idx    = {regs_q.cmd[7:6], bus_addr};
    assign is_cmd = (bus_addr == 4'h0);
    assign tbl_wr = bus_wr && !is_cmd;
    assign wval   = {1'b0, bus_wdata};
    assign lim_ok = (wval <= END_PG);
    assign ptr_ok = (wval <  END_PG);

    always_comb begin
        regs_d       = regs_q;
        regs_d.tx_go = 1'b0;
        set_bits     = 8'h00;
        set_bits[ST_RX]  = rx_ok_evt;
        set_bits[ST_RDC] = rdma_done_evt;
        rst_clr = 1'b0;
        w1c_en  = 1'b0;
        mask_we = 1'b0;
        if (bus_wr) begin
            if (is_cmd) begin
                regs_d.cmd = bus_wdata;
                if (!bus_wdata[CMD_STOP]) begin
                    rst_clr = 1'b1;
                    if ((bus_wdata[CMD_RREAD] || bus_wdata[CMD_RWRITE]) &&
                        (regs_q.rcnt == 16'h0000)) begin
                        set_bits[ST_RDC] = 1'b1;
                    end
                    if (bus_wdata[CMD_XMIT]) begin
                        regs_d.tx_go         = 1'b1;
                        regs_d.tx_stat       = 8'h01;
                        set_bits[ST_TX]      = 1'b1;
                        regs_d.cmd[CMD_XMIT] = 1'b0;
                    end
                end
            end else begin
                case (idx)
                    P0_RING_FIRST: if (lim_ok) regs_d.ring_first = bus_wdata;
                    P0_RING_END:   if (lim_ok) regs_d.ring_end   = bus_wdata;
                    P0_BNDRY:      if (ptr_ok) regs_d.bndry      = bus_wdata;
                    P1_CURPG:      if (ptr_ok) regs_d.cur_pg     = bus_wdata;
                    P0_TXPG:       regs_d.tx_pg           = bus_wdata;
                    P0_TXCNT_LO:   regs_d.tx_cnt[7:0]     = bus_wdata;
                    P0_TXCNT_HI:   regs_d.tx_cnt[15:8]    = bus_wdata;
                    P0_RADDR_LO:   regs_d.raddr[7:0]      = bus_wdata;
                    P0_RADDR_HI:   regs_d.raddr[15:8]     = bus_wdata;
                    P0_RCNT_LO:    regs_d.rcnt[7:0]       = bus_wdata;
                    P0_RCNT_HI:    regs_d.rcnt[15:8]      = bus_wdata;
                    P0_RXCFG:      regs_d.rx_cfg          = bus_wdata;
                    P0_DATACFG:    regs_d.data_cfg        = bus_wdata;
                    P0_STATUS:     w1c_en  = 1'b1;
                    P0_MASK:       mask_we = 1'b1;
                    default:       ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    nic_intr_ctrl u_intr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (set_bits),
        .w1c_en     (w1c_en),
        .w1c_bits   (bus_wdata),
        .rst_clr    (rst_clr),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    nic_byte_table #(.N(STATION_N), .BASE(P1_STATION)) u_station (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (tbl_wr),
        .idx   (idx),
        .wdata (bus_wdata),
        .hit   (stn_hit),
        .rdata (stn_data)
    );

    nic_byte_table #(.N(HASH_N), .BASE(P1_HASH)) u_hash (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (tbl_wr),
        .idx   (idx),
        .wdata (bus_wdata),
        .hit   (hash_hit),
        .rdata (hash_data)
    );

    nic_read_mux #(.ID0(ID0), .ID1(ID1)) u_rmux (
        .is_cmd    (is_cmd),
        .idx       (idx),
        .regs      (regs_q),
        .status    (status_q),
        .stn_hit   (stn_hit),
        .stn_data  (stn_data),
        .hash_hit  (hash_hit),
        .hash_data (hash_data),
        .rdata     (bus_rdata)
    );

    assign tx_go    = regs_q.tx_go;
    assign tx_page  = regs_q.tx_pg;
    assign tx_len   = regs_q.tx_cnt;
    assign rx_cfg   = regs_q.rx_cfg;
    assign data_cfg = regs_q.data_cfg;
endmodule

// File: rtl/nic_regs_chk.sv
module nic_regs_chk #(
    parameter int MEM_END_PAGE = 8'h80
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       irq,
    input logic       tx_go,
    input logic [7:0] cmd,
    input logic [7:0] status,
    input logic [7:0] mask,
    input logic [7:0] tx_stat,
    input logic [7:0] bndry
);
    localparam logic [8:0] END_PG = 9'(MEM_END_PAGE);

    logic on_p0;
    assign on_p0 = (cmd[7:6] == 2'b00);

    // R10
    status_top_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && on_p0 && bus_addr == 4'h7) |=> (status[7] == $past(status[7])));

    // R7
    rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(bus_wr && bus_addr == 4'h0 && !bus_wdata[0]));

    // R9
    tx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> $past(bus_wr && bus_addr == 4'h0 && bus_wdata[2] && !bus_wdata[0]));

    // R9
    tx_side_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> (tx_stat == 8'h01 && status[1] && !cmd[2]));

    // R11
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq);

    // R6
    bndry_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && on_p0 && bus_addr == 4'h3 && {1'b0, bus_wdata} >= END_PG)
        |=> $stable(bndry));
endmodule

bind paged_nic_regs nic_regs_chk #(.MEM_END_PAGE(MEM_END_PAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .tx_go     (tx_go),
    .cmd       (regs_q.cmd),
    .status    (status_q),
    .mask      (mask_q),
    .tx_stat   (regs_q.tx_stat),
    .bndry     (regs_q.bndry)
);

// File: tb/paged_nic_regs_tb.sv
`timescale 1ns/1ps
module paged_nic_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic        rx_ok_evt = 1'b0;
    logic        rdma_done_evt = 1'b0;
    logic        tx_go;
    logic [7:0]  tx_page;
    logic [15:0] tx_len;
    logic [7:0]  rx_cfg;
    logic [7:0]  data_cfg;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    paged_nic_regs u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq           (irq),
        .rx_ok_evt     (rx_ok_evt),
        .rdma_done_evt (rdma_done_evt),
        .tx_go         (tx_go),
        .tx_page       (tx_page),
        .tx_len        (tx_len),
        .rx_cfg        (rx_cfg),
        .data_cfg      (data_cfg)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] a;
        logic [7:0] d;
        logic [7:0] e;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h7, 8'hFF, 8'h00, 4'd10},  // R10 clear all
        '{1'b0, 4'h7, 8'h00, 8'h80, 4'd10},  // R10 bit 7 kept
        '{1'b0, 4'h0, 8'h00, 8'h00, 4'd1},   // R1
        '{1'b0, 4'hA, 8'h00, 8'h50, 4'd13},  // R13
        '{1'b0, 4'hB, 8'h00, 8'h43, 4'd13},  // R13
        '{1'b0, 4'hC, 8'h00, 8'h00, 4'd13},  // R13 unmapped read
        '{1'b1, 4'h1, 8'h40, 8'h00, 4'd3},   // R3
        '{1'b1, 4'h2, 8'h80, 8'h00, 4'd6},   // R6 equal limit accepted
        '{1'b1, 4'h3, 8'h4C, 8'h00, 4'd3},
        '{1'b0, 4'h3, 8'h00, 8'h4C, 4'd3},
        '{1'b1, 4'h3, 8'h80, 8'h00, 4'd6},   // R6 rejected
        '{1'b0, 4'h3, 8'h00, 8'h4C, 4'd6},
        '{1'b1, 4'h8, 8'h34, 8'h00, 4'd5},   // R5
        '{1'b1, 4'h9, 8'h12, 8'h00, 4'd5},
        '{1'b0, 4'h8, 8'h00, 8'h34, 4'd5},
        '{1'b0, 4'h9, 8'h00, 8'h12, 4'd5},
        '{1'b1, 4'h8, 8'h56, 8'h00, 4'd5},
        '{1'b0, 4'h9, 8'h00, 8'h12, 4'd5},
        '{1'b0, 4'h8, 8'h00, 8'h56, 4'd5},
        '{1'b1, 4'h0, 8'h40, 8'h00, 4'd2},   // R2 page 1
        '{1'b0, 4'h0, 8'h00, 8'h40, 4'd2},
        '{1'b1, 4'h1, 8'hAA, 8'h00, 4'd4},   // R4
        '{1'b1, 4'h6, 8'hBB, 8'h00, 4'd4},
        '{1'b1, 4'h7, 8'h7F, 8'h00, 4'd4},
        '{1'b1, 4'h8, 8'h11, 8'h00, 4'd4},
        '{1'b1, 4'hF, 8'h22, 8'h00, 4'd4},
        '{1'b0, 4'h1, 8'h00, 8'hAA, 4'd4},
        '{1'b0, 4'h6, 8'h00, 8'hBB, 4'd4},
        '{1'b0, 4'h7, 8'h00, 8'h7F, 4'd4},
        '{1'b0, 4'h8, 8'h00, 8'h11, 4'd4},
        '{1'b0, 4'hF, 8'h00, 8'h22, 4'd4},
        '{1'b1, 4'h7, 8'h80, 8'h00, 4'd6},   // R6 current page rejected
        '{1'b0, 4'h7, 8'h00, 8'h7F, 4'd6},
        '{1'b0, 4'hA, 8'h00, 8'h00, 4'd2},   // R2 table byte, not identity
        '{1'b1, 4'h0, 8'h80, 8'h00, 4'd2},   // page 2
        '{1'b0, 4'h1, 8'h00, 8'h40, 4'd4},
        '{1'b0, 4'h2, 8'h00, 8'h80, 4'd4},
        '{1'b1, 4'h0, 8'h00, 8'h00, 4'd2},   // page 0
        '{1'b1, 4'h1, 8'h81, 8'h00, 4'd6},   // R6 over limit
        '{1'b1, 4'h0, 8'h80, 8'h00, 4'd2},
        '{1'b0, 4'h1, 8'h00, 8'h40, 4'd6},
        '{1'b0, 4'h5, 8'h00, 8'h00, 4'd13},
        '{1'b1, 4'h0, 8'h00, 8'h00, 4'd2},
        '{1'b0, 4'h7, 8'h00, 8'h00, 4'd7}    // R7 bit 7 cleared earlier
    };

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        applied++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [3:0] a, logic [7:0] e);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(req, {8'h00, bus_rdata}, {8'h00, e});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        #1;
        chk("R1", {15'h0, irq}, 16'h0);
        chk("R1", {15'h0, tx_go}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
            else           rd($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].a, VEC[i].e);
        end

        // R9 transmit
        wr(4'h4, 8'h20); wr(4'h5, 8'h3C); wr(4'h6, 8'h01);
        wr(4'h0, 8'h06);
        chk("R9 tx_go", {15'h0, tx_go}, 16'h1);
        chk("R9 tx_page", {8'h0, tx_page}, 16'h0020);
        chk("R9 tx_len", tx_len, 16'h013C);
        @(negedge clk);
        chk("R9 pulse width", {15'h0, tx_go}, 16'h0);
        rd("R9 xmit bit cleared", 4'h0, 8'h02);
        rd("R9 tx status", 4'h4, 8'h01);
        rd("R9 status bit1", 4'h7, 8'h02);
        chk("R11 masked", {15'h0, irq}, 16'h0);
        wr(4'hF, 8'h02);
        chk("R11 unmasked", {15'h0, irq}, 16'h1);
        wr(4'h5, 8'h40);
        chk("R5 tx_len high kept", tx_len, 16'h0140);
        wr(4'h7, 8'h02);
        rd("R10 clear bit1", 4'h7, 8'h00);
        chk("R11 after clear", {15'h0, irq}, 16'h0);

        // R8 zero-count remote DMA
        wr(4'h0, 8'h0A);
        rd("R8 zero count", 4'h7, 8'h40);
        wr(4'h7, 8'h40);
        wr(4'hA, 8'h05);
        wr(4'h0, 8'h12);
        rd("R8 nonzero count", 4'h7, 8'h00);

        // R12 events and same-cycle priority
        wr(4'hF, 8'h41);
        @(negedge clk); rx_ok_evt = 1'b1;
        @(negedge clk); rx_ok_evt = 1'b0;
        rd("R12 rx event", 4'h7, 8'h01);
        chk("R12 irq", {15'h0, irq}, 16'h1);
        @(negedge clk);
        bus_addr = 4'h7; bus_wdata = 8'h01; bus_wr = 1'b1; rx_ok_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_ok_evt = 1'b0;
        rd("R10 set beats clear", 4'h7, 8'h01);
        wr(4'h7, 8'h01);
        @(negedge clk); rdma_done_evt = 1'b1;
        @(negedge clk); rdma_done_evt = 1'b0;
        rd("R12 dma event", 4'h7, 8'h40);
        chk("R12 dma irq", {15'h0, irq}, 16'h1);
        wr(4'h7, 8'hFF);
        chk("R11 cleared", {15'h0, irq}, 16'h0);

        // R1 / R7 / R11 after a second reset
        do_reset();
        #1;
        chk("R1 irq", {15'h0, irq}, 16'h0);
        chk("R1 tx_len", tx_len, 16'h0);
        rd("R1 status", 4'h7, 8'h80);
        rd("R1 cmd", 4'h0, 8'h00);
        wr(4'hF, 8'hFF);
        chk("R11 bit7 excluded", {15'h0, irq}, 16'h0);
        wr(4'h0, 8'h21);
        rd("R7 stop keeps bit7", 4'h7, 8'h80);
        wr(4'h0, 8'h05);
        chk("R7 stop blocks tx", {15'h0, tx_go}, 16'h0);
        rd("R7 no tx status", 4'h4, 8'h00);
        rd("R7 cmd stored", 4'h0, 8'h05);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule